// File: doc/BRIEF.md
# Two-Way Cache Flush Sequencer

This block walks the tag store of a two-way set-associative cache when software sets a flush control bit. It visits every set of way 0 in ascending order, then goes back to set 0 and visits every set of way 1. At each entry it reads the status word and raises one castout request for each modified sector of a valid line, waiting for an acknowledge before moving on. A second pass then writes an all-zero status word into every entry. After the last write the flush bit clears itself and a one-cycle done pulse is raised.

The flush bit stays high for the whole operation and drives the core-block output, which shuts instruction and data accesses out of the cache. Snoops keep priority over the tag port at all times. In any cycle where a snoop is pending, the sequencer holds its position and does not use the port. The bit clears as soon as the tags are invalidated. Castouts still queued beyond the acknowledge are not waited for.

Top module: `flush_seq_top`

## Requirements
- R1: After reset, flushBit, coreBlock, coReq, tagEn and doneP are all low.
- R2: A flushSet pulse seen at a rising edge while idle makes flushBit and coreBlock high from the next cycle until the flush ends.
- R3: Tag reads (tagEn high, tagWe low) visit {tagWay,tagIdx} in ascending order: way 0 sets 0 to NUM_SETS-1, then way 1 sets 0 to NUM_SETS-1, each exactly once.
- R4: The read status word arrives on tagRdata the cycle after the read. Bit SECTORS is the valid bit and bit s (s < SECTORS) is the modified flag of sector s. One castout request is issued for each sector whose modified flag is set in a valid entry, in ascending sector order. No request is issued for clean sectors or invalid entries.
- R5: A castout request holds coReq, coWay, coIdx and coSector stable until coAck is high at a rising edge.
- R6: After the last castout, every entry is written once with tagWdata all zero, in the same way-major ascending order.
- R7: While snoopReq is high, tagEn is low. The walk then resumes at the same entry, with nothing skipped or repeated.
- R8: In the cycle after the last invalidate write, flushBit is low and doneP is high for exactly one cycle.
- R9: A flushSet pulse during a flush is ignored: the walk is neither restarted nor lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flushSet | input | 1 | Software write that sets the flush bit |
| snoopReq | input | 1 | Snoop needs the tag port this cycle |
| tagRdata | input | SECTORS+1 | Status word read one cycle after a read |
| coAck | input | 1 | Castout accepted |
| flushBit | output | 1 | Flush control bit as read by software |
| coreBlock | output | 1 | Blocks core accesses to the cache |
| doneP | output | 1 | One-cycle pulse when the bit self-clears |
| tagEn | output | 1 | Tag port access by the sequencer |
| tagWe | output | 1 | Tag write (invalidate) when set with tagEn |
| tagWay | output | 1 | Way of the tag access |
| tagIdx | output | log2(NUM_SETS) | Set index of the tag access |
| tagWdata | output | SECTORS+1 | Status word written (all zero) |
| coReq | output | 1 | Castout request |
| coWay | output | 1 | Way of the castout line |
| coIdx | output | log2(NUM_SETS) | Set index of the castout line |
| coSector | output | log2(SECTORS) | Sector being cast out |

## Verification
The flush bit rises one cycle after the edge that captures flushSet. Tag status is returned one cycle after each read. A castout completes at the edge where coReq and coAck are both high. The done pulse and the fall of the flush bit come exactly one cycle after the final invalidate write. The bench drives inputs one time unit after the rising edge and samples every output at the falling edge. It counts falling edges so it can compare the done pulse against the recorded cycle of the last write. Each tag access and each accepted castout is checked at the moment it happens against lists computed in the bench from the status pattern it loaded. This is repeated under several acknowledge latencies, with snoop interference and with a redundant trigger.

// File: rtl/flush_pkg.sv
package flush_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_CAPT,
    S_SCAN,
    S_INVAL
  } seqState_t;

  typedef struct packed {
    logic setBusy;
    logic clrBusy;
    logic clrWalk;
    logic incWalk;
    logic loadMask;
    logic clrSec;
    logic incSec;
  } dpCtl_t;

  typedef struct packed {
    logic walkLast;
    logic secLast;
    logic curDirty;
  } dpStat_t;
endpackage

// File: rtl/flush_ctl.sv
module flush_ctl
  import flush_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    flushSet,
  input  logic    snoopReq,
  input  logic    coAck,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    tagEn,
  output logic    tagWe,
  output logic    coReq
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    tagEn     = 1'b0;
    tagWe     = 1'b0;
    coReq     = 1'b0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (flushSet) begin
          ctl.setBusy = 1'b1;
          ctl.clrWalk = 1'b1;
          nextState   = S_READ;
        end
      end
      S_READ: begin
        if (!snoopReq) begin
          tagEn     = 1'b1;
          nextState = S_CAPT;
        end
      end
      S_CAPT: begin
        ctl.loadMask = 1'b1;
        ctl.clrSec   = 1'b1;
        nextState    = S_SCAN;
      end
      S_SCAN: begin
        coReq = stat.curDirty;
        if (!stat.curDirty || coAck) begin
          if (stat.secLast) begin
            if (stat.walkLast) begin
              ctl.clrWalk = 1'b1;
              nextState   = S_INVAL;
            end else begin
              ctl.incWalk = 1'b1;
              nextState   = S_READ;
            end
          end else begin
            ctl.incSec = 1'b1;
          end
        end
      end
      S_INVAL: begin
        if (!snoopReq) begin
          tagEn = 1'b1;
          tagWe = 1'b1;
          if (stat.walkLast) begin
            ctl.clrBusy = 1'b1;
            nextState   = S_IDLE;
          end else begin
            ctl.incWalk = 1'b1;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  // R7: a pending snoop owns the tag port
  p_snoop_yield_r7: assert property (@(posedge clk) disable iff (!rstN)
    snoopReq |-> !tagEn);

  // R5: an unacknowledged castout stays raised
  p_co_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (coReq && !coAck) |=> coReq);
endmodule

// File: rtl/flush_dp.sv
module flush_dp
  import flush_pkg::*;
#(
  parameter int NUM_SETS = 8,
  parameter int SECTORS  = 4,
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int SEC_W   = $clog2(SECTORS),
  localparam int STAT_W  = SECTORS + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [STAT_W-1:0] tagRdata,
  output dpStat_t           stat,
  output logic              flushBit,
  output logic              doneP,
  output logic              curWay,
  output logic [IDX_W-1:0]  curIdx,
  output logic [SEC_W-1:0]  curSec
);
  logic [IDX_W:0]       walkCnt;
  logic [SEC_W-1:0]     secCnt;
  logic [SECTORS-1:0]   maskReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      walkCnt  <= '0;
      secCnt   <= '0;
      maskReg  <= '0;
      flushBit <= 1'b0;
      doneP    <= 1'b0;
    end else begin
      if (ctl.clrWalk)      walkCnt <= '0;
      else if (ctl.incWalk) walkCnt <= walkCnt + 1'b1;
      if (ctl.clrSec)       secCnt  <= '0;
      else if (ctl.incSec)  secCnt  <= secCnt + 1'b1;
      if (ctl.loadMask)
        maskReg <= tagRdata[SECTORS] ? tagRdata[SECTORS-1:0] : '0;
      if (ctl.setBusy)      flushBit <= 1'b1;
      else if (ctl.clrBusy) flushBit <= 1'b0;
      doneP <= ctl.clrBusy;
    end
  end

  assign stat.walkLast = &walkCnt;
  assign stat.secLast  = (secCnt == SEC_W'(SECTORS - 1));
  assign stat.curDirty = maskReg[secCnt];
  assign curWay = walkCnt[IDX_W];
  assign curIdx = walkCnt[IDX_W-1:0];
  assign curSec = secCnt;

  // R8: done is a single pulse coinciding with the bit falling
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);
  p_done_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> (!flushBit && $past(flushBit)));
endmodule

// File: rtl/flush_seq_top.sv
module flush_seq_top
  import flush_pkg::*;
#(
  parameter int NUM_SETS = 8,
  parameter int SECTORS  = 4,
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int SEC_W   = $clog2(SECTORS),
  localparam int STAT_W  = SECTORS + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushSet,
  input  logic              snoopReq,
  input  logic [STAT_W-1:0] tagRdata,
  input  logic              coAck,
  output logic              flushBit,
  output logic              coreBlock,
  output logic              doneP,
  output logic              tagEn,
  output logic              tagWe,
  output logic              tagWay,
  output logic [IDX_W-1:0]  tagIdx,
  output logic [STAT_W-1:0] tagWdata,
  output logic              coReq,
  output logic              coWay,
  output logic [IDX_W-1:0]  coIdx,
  output logic [SEC_W-1:0]  coSector
);
  dpCtl_t           ctl;
  dpStat_t          stat;
  logic             curWay;
  logic [IDX_W-1:0] curIdx;
  logic [SEC_W-1:0] curSec;

  flush_ctl u_ctl (
    .clk(clk), .rstN(rstN), .flushSet(flushSet), .snoopReq(snoopReq),
    .coAck(coAck), .stat(stat), .ctl(ctl), .tagEn(tagEn), .tagWe(tagWe),
    .coReq(coReq)
  );

  flush_dp #(.NUM_SETS(NUM_SETS), .SECTORS(SECTORS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tagRdata(tagRdata), .stat(stat),
    .flushBit(flushBit), .doneP(doneP), .curWay(curWay), .curIdx(curIdx),
    .curSec(curSec)
  );

  assign coreBlock = flushBit;
  assign tagWay    = curWay;
  assign tagIdx    = curIdx;
  assign tagWdata  = '0;
  assign coWay     = curWay;
  assign coIdx     = curIdx;
  assign coSector  = curSec;

  // R5: castout target stays put until accepted
  p_co_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (coReq && !coAck) |=> ($stable(coWay) && $stable(coIdx) && $stable(coSector)));

  // R2: castouts and tag traffic only happen while core is blocked
  p_block_co_r2: assert property (@(posedge clk) disable iff (!rstN)
    coReq |-> coreBlock);
  p_block_tag_r2: assert property (@(posedge clk) disable iff (!rstN)
    tagEn |-> coreBlock);
endmodule

// File: tb/sim_flush_seq_top.sv
module sim_flush_seq_top;
  localparam int NS = 8;
  localparam int SC = 4;
  localparam int IW = 3;
  localparam int SW = 2;
  localparam int ST = SC + 1;
  localparam int NE = 2 * NS;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, flushSet, snoopReq, coAck;
  logic [ST-1:0] tagRdata;
  logic flushBit, coreBlock, doneP, tagEn, tagWe, tagWay, coReq, coWay;
  logic [IW-1:0] tagIdx, coIdx;
  logic [ST-1:0] tagWdata;
  logic [SW-1:0] coSector;

  flush_seq_top #(.NUM_SETS(NS), .SECTORS(SC)) u0 (
    .clk(clk), .rstN(rstN), .flushSet(flushSet), .snoopReq(snoopReq),
    .tagRdata(tagRdata), .coAck(coAck), .flushBit(flushBit),
    .coreBlock(coreBlock), .doneP(doneP), .tagEn(tagEn), .tagWe(tagWe),
    .tagWay(tagWay), .tagIdx(tagIdx), .tagWdata(tagWdata), .coReq(coReq),
    .coWay(coWay), .coIdx(coIdx), .coSector(coSector)
  );

  int chk = 0, bad = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    chk++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic [ST-1:0] mem [NE];
  int expEnt [NE*SC];
  int expSec [NE*SC];
  int expN;
  int cyc = 0, waitCnt = 0, ackLat = 0;
  bit snoopOn = 0;

  // tag store and acknowledge model
  always @(posedge clk) begin
    if (tagEn && !tagWe) tagRdata <= mem[int'({tagWay, tagIdx})];
    if (tagEn && tagWe)  mem[int'({tagWay, tagIdx})] <= tagWdata;
    cyc <= cyc + 1;
    if (coReq && !coAck) waitCnt <= waitCnt + 1;
    else                 waitCnt <= 0;
  end
  assign coAck    = coReq && (waitCnt >= ackLat);
  assign snoopReq = snoopOn && (cyc % 4 == 1);

  int rdPtr, wrPtr, coPtr, doneCnt, lastWr, ncyc = 0;
  bit held;
  int hEnt, hSec;

  // monitor at falling edge
  always @(negedge clk) begin
    ncyc++;
    if (rstN) begin
      if (held)
        check(coReq && int'({coWay, coIdx}) == hEnt && int'(coSector) == hSec,
              "R5 hold", int'({coWay, coIdx}), hEnt);
      held = coReq && !coAck;
      hEnt = int'({coWay, coIdx});
      hSec = int'(coSector);
      if (snoopReq) check(!tagEn, "R7 snoop yield", int'(tagEn), 0);
      if (tagEn && !tagWe) begin
        check(int'({tagWay, tagIdx}) == rdPtr, "R3 read order", int'({tagWay, tagIdx}), rdPtr);
        rdPtr++;
      end
      if (tagEn && tagWe) begin
        check(int'({tagWay, tagIdx}) == wrPtr && tagWdata == '0, "R6 invalidate order",
              int'({tagWay, tagIdx}), wrPtr);
        wrPtr++;
        lastWr = ncyc;
      end
      if (coReq && coAck) begin
        if (coPtr < expN)
          check(int'({coWay, coIdx}) == expEnt[coPtr] && int'(coSector) == expSec[coPtr],
                "R4 castout", int'({coWay, coIdx}) * 16 + int'(coSector),
                expEnt[coPtr] * 16 + expSec[coPtr]);
        else
          check(0, "R4 extra castout", coPtr, expN);
        coPtr++;
      end
      if (doneP) begin
        doneCnt++;
        check(wrPtr == NE && ncyc == lastWr + 1 && !flushBit, "R8 done timing",
              ncyc - lastWr, 1);
      end
    end
  end

  task automatic prepare(input int seed);
    expN = 0;
    for (int e = 0; e < NE; e++) begin
      logic [ST-1:0] v;
      v = (seed < 0) ? '1 : ST'((e * 11 + seed * 5 + (e >> 2)) & 31);
      mem[e] = v;
      if (v[SC])
        for (int s = 0; s < SC; s++)
          if (v[s]) begin
            expEnt[expN] = e;
            expSec[expN] = s;
            expN++;
          end
    end
    rdPtr = 0; wrPtr = 0; coPtr = 0; doneCnt = 0; lastWr = -10; held = 0;
  endtask

  task automatic runFlush(input int seed, input int lat, input bit snp, input bit extra);
    int n;
    bit allZero;
    prepare(seed);
    ackLat  = lat;
    snoopOn = snp;
    @(posedge clk); #1 flushSet = 1'b1;
    @(posedge clk); #1 flushSet = 1'b0;
    @(negedge clk);
    check(flushBit && coreBlock, "R2 bit set", int'(flushBit), 1);
    if (extra) begin
      repeat (20) @(posedge clk);
      #1 flushSet = 1'b1;
      @(posedge clk); #1 flushSet = 1'b0;
      check(flushBit && coreBlock, "R2 still busy", int'(flushBit), 1);
    end
    n = 0;
    while (doneCnt == 0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check(doneCnt == 1, "R8 completion watchdog", doneCnt, 1);
    repeat (3) @(negedge clk);
    check(rdPtr == NE, "R3 read count", rdPtr, NE);
    check(wrPtr == NE, "R6 write count", wrPtr, NE);
    check(coPtr == expN, "R4 castout count", coPtr, expN);
    check(doneCnt == 1, "R9 no restart", doneCnt, 1);
    check(!flushBit && !coreBlock, "R8 bit cleared", int'(flushBit), 0);
    allZero = 1;
    for (int e = 0; e < NE; e++) if (mem[e] != '0) allZero = 0;
    check(allZero, "R6 tags zero", int'(allZero), 1);
    snoopOn = 0;
  endtask

  initial begin
    rstN = 1'b0;
    flushSet = 1'b0;
    for (int e = 0; e < NE; e++) mem[e] = '0;
    tagRdata = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!flushBit, "R1 flushBit", int'(flushBit), 0);
    check(!coreBlock, "R1 coreBlock", int'(coreBlock), 0);
    check(!coReq, "R1 coReq", int'(coReq), 0);
    check(!tagEn, "R1 tagEn", int'(tagEn), 0);
    check(!doneP, "R1 doneP", int'(doneP), 0);
    runFlush(1, 0, 0, 0);
    runFlush(6, 2, 1, 1);
    runFlush(-1, 1, 0, 0);
    runFlush(13, 0, 1, 0);
    runFlush(22, 3, 1, 1);
    $display("%0d/%0d checks passed", chk - bad, chk);
    $finish;
  end
endmodule